// File: doc/BRIEF.md
# Ordered Clock Reconfiguration Sequencer

This block moves one PLL and the group of integer dividers fed by it to a new operating point, chosen by an index into a table of presets. Each preset holds three things: the PLL target rate, the configuration word written to the PLL control register, and one 8-bit value for each divider. All table contents are elaboration parameters. The block drives the PLL, the dividers and an optional core-interface divider through a single-cycle write port. It samples lock and error status from the PLL.

The sequencer compares the target rate with the rate it last programmed. If the target is lower, the PLL is reprogrammed first and the dividers follow. Otherwise the dividers are written first and the PLL follows. This order means no divided output runs faster than its final rate while the change is in progress. After the PLL write, the block waits a fixed lock interval counted in system clock cycles. It then reads the status and reports success, a lock timeout or a status error. When built for a core PLL, a core-interface divider is set to divide-by-2 before the rate rises above a threshold. It is set back to divide-by-1 only after a clean relock at or below that threshold.

Top module: `clk_retarget_seq`

## Requirements
- R1: While reset is held, and after it is released, `busy`, `done` and `wr_en` are low.
- R2: A `start` seen while idle latches `idx` and raises `busy` from the next cycle through the `done` cycle. A `start` while `busy` is high is ignored: it changes neither the write sequence nor the result, and no second sequence follows.
- R3: An index at or beyond `NUM_PTS`, or one whose preset rate is zero, ends the sequence with `result` = 3 and no write at all.
- R4: If the target rate is greater than or equal to the current rate, every divider write comes before the PLL write.
- R5: If the target rate is below the current rate, the PLL write comes first. The divider writes follow only after a successful relock.
- R6: Divider writes go one per cycle, in table order k = 0 .. NUM_DIV-1, to address `DIV_BASE + k*DIV_STRIDE`. The data is the 8-bit preset value zero-extended, so the value 0 (output off) is written as given.
- R7: The PLL write goes to `PLL_ADDR` with the preset configuration word. Lock and error are sampled at the end of the `LOCK_CYC = CLK_MHZ*LOCK_US`-th cycle after the PLL write cycle.
- R8: If lock is low at that sample, the sequence ends with `result` = 1 (timeout) and makes no further write.
- R9: If lock is high and error is high at that sample, the sequence ends with `result` = 2 (bad status) and makes no further write.
- R10: A sequence that completes every write ends with `result` = 0.
- R11: In core mode, a target above `THRESH_MHZ` causes a write of data 1 (divide-by-2) to `IFDIV_ADDR` in the cycle just before the PLL write.
- R12: In core mode, a target at or below `THRESH_MHZ` causes a write of data 0 (divide-by-1) to `IFDIV_ADDR` right after a successful relock, before any remaining divider writes. It is never written after a failed relock.
- R13: The current rate becomes the target rate at the PLL write, even if the relock later fails. That value is the basis for the next comparison. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to move to the preset at `idx` |
| idx | input | IDX_W | Preset index |
| pll_lock | input | 1 | PLL lock status |
| pll_err | input | 1 | PLL error status |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 timeout, 2 bad status, 3 bad index |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | DATA_W | Register write data |

## Verification
The bench sweeps every ordered pair of presets, so it covers rises, falls and equal rates, and targets on both sides of the threshold. A design that compared with a strict "greater than" would put the PLL first on an equal rate, and one that ignored the threshold edge would misplace the interface-divider write at exactly 500. The bench moves the lock edge between the last cycle of the window and one cycle later. A timer that is off by one turns a pass into a timeout, or the reverse. Failed relocks, bad-status relocks, a hole in the table, an out-of-range index and a zero divider value are each checked for stray writes, and a bad index also for any write at all. A comparison against the rate held before a failed relock would pick the wrong order on the next request.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CHECK = 3'd1,
      ST_DIV   = 3'd2,
      ST_IFHI  = 3'd3,
      ST_PLL   = 3'd4,
      ST_WAIT  = 3'd5,
      ST_IFLO  = 3'd6,
      ST_DONE  = 3'd7
   } seq_state_t;

   typedef enum logic [1:0] {
      RES_OK      = 2'd0,
      RES_TIMEOUT = 2'd1,
      RES_BADSTAT = 2'd2,
      RES_BADIDX  = 2'd3
   } seq_res_t;

   localparam int unsigned DIV_VAL_W = 8;

endpackage

// File: rtl/clkseq_table.sv
module clkseq_table #(
   parameter int unsigned NUM_PTS = 4,
   parameter int unsigned NUM_DIV = 3,
   parameter int unsigned IDX_W   = 2,
   parameter int unsigned RATE_W  = 16,
   parameter int unsigned CFG_W   = 32,
   parameter logic [NUM_PTS*RATE_W-1:0]  PT_RATE = '0,
   parameter logic [NUM_PTS*CFG_W-1:0]   PT_CFG  = '0,
   parameter logic [NUM_PTS*NUM_DIV*8-1:0] PT_DIV = '0
) (
   input  logic [IDX_W-1:0]       sel,
   output logic                   hit,
   output logic [RATE_W-1:0]      rate,
   output logic [CFG_W-1:0]       cfg,
   output logic [NUM_DIV*8-1:0]   divs
);

   localparam int unsigned ROW_W = NUM_DIV * 8;

   logic [RATE_W-1:0] rate_arr [NUM_PTS];
   logic [CFG_W-1:0]  cfg_arr  [NUM_PTS];
   logic [ROW_W-1:0]  div_arr  [NUM_PTS];

   for (genvar p = 0; p < NUM_PTS; p++) begin : g_pt
      assign rate_arr[p] = PT_RATE[p*RATE_W +: RATE_W];
      assign cfg_arr[p]  = PT_CFG[p*CFG_W +: CFG_W];
      assign div_arr[p]  = PT_DIV[p*ROW_W +: ROW_W];
   end

   logic in_range;

   always_comb begin
      in_range = 1'b0;
      rate     = '0;
      cfg      = '0;
      divs     = '0;
      for (int p = 0; p < NUM_PTS; p++) begin
         if (int'(sel) == p) begin
            in_range = 1'b1;
            rate     = rate_arr[p];
            cfg      = cfg_arr[p];
            divs     = div_arr[p];
         end
      end
   end

   // a preset with a zero rate is a hole in the table
   assign hit = in_range && (rate != '0);

endmodule

// File: rtl/clkseq_lock_timer.sv
module clkseq_lock_timer #(
   parameter int unsigned LOCK_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic running,
   output logic expire
);

   localparam int unsigned CW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC + 1) : 1;

   logic [CW-1:0] cnt_q;
   logic          active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         cnt_q    <= CW'(LOCK_CYC - 1);
         active_q <= 1'b1;
      end else if (active_q) begin
         if (cnt_q == '0) begin
            active_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign running = active_q;
   assign expire  = active_q && (cnt_q == '0);

   AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !active_q); // R7
   AST_EXPIRE_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !running); // R7

endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
   import clkseq_pkg::*;
#(
   parameter int unsigned NUM_DIV    = 3,
   parameter int unsigned IDX_W      = 2,
   parameter int unsigned RATE_W     = 16,
   parameter int unsigned CFG_W      = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned INIT_RATE  = 400,
   parameter int unsigned THRESH_MHZ = 500,
   parameter bit          IS_CORE    = 1'b1,
   parameter int unsigned PLL_ADDR   = 0,
   parameter int unsigned IFDIV_ADDR = 4,
   parameter int unsigned DIV_BASE   = 16,
   parameter int unsigned DIV_STRIDE = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [IDX_W-1:0]     idx,
   input  logic                 pll_lock,
   input  logic                 pll_err,
   input  logic                 tbl_hit,
   input  logic [RATE_W-1:0]    tbl_rate,
   input  logic [CFG_W-1:0]     tbl_cfg,
   input  logic [NUM_DIV*8-1:0] tbl_divs,
   input  logic                 timer_expire,
   input  logic                 timer_running,
   output logic [IDX_W-1:0]     sel,
   output logic                 timer_load,
   output logic                 busy,
   output logic                 done,
   output logic [1:0]           result,
   output logic                 wr_en,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [DATA_W-1:0]    wr_data
);

   localparam int unsigned PW = (NUM_DIV > 1) ? $clog2(NUM_DIV) : 1;
   localparam logic [PW-1:0]     LAST   = PW'(NUM_DIV - 1);
   localparam logic [RATE_W-1:0] THR_R  = RATE_W'(THRESH_MHZ);
   localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(PLL_ADDR);
   localparam logic [ADDR_W-1:0] A_IF   = ADDR_W'(IFDIV_ADDR);
   localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(DIV_BASE);
   localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(DIV_STRIDE);

   seq_state_t        state_q, state_d;
   seq_res_t          res_q, res_d;
   logic [PW-1:0]     ptr_q, ptr_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [RATE_W-1:0] cur_q, cur_d;
   logic              down_q, down_d;
   logic              rise_if, fall_if;

   // core variant: interface divider follows the threshold
   if (IS_CORE) begin : g_core
      assign rise_if = tbl_rate > THR_R;
      assign fall_if = !(tbl_rate > THR_R);
   end else begin : g_plain
      assign rise_if = 1'b0;
      assign fall_if = 1'b0;
   end

   always_comb begin
      state_d = state_q;
      res_d   = res_q;
      ptr_d   = ptr_q;
      idx_d   = idx_q;
      cur_d   = cur_q;
      down_d  = down_q;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               idx_d   = idx;
               res_d   = RES_OK;
               state_d = ST_CHECK;
            end
         end
         ST_CHECK: begin
            ptr_d = '0;
            if (!tbl_hit) begin
               res_d   = RES_BADIDX;
               state_d = ST_DONE;
            end else if (tbl_rate < cur_q) begin
               down_d  = 1'b1;
               state_d = rise_if ? ST_IFHI : ST_PLL;
            end else begin
               down_d  = 1'b0;
               state_d = ST_DIV;
            end
         end
         ST_DIV: begin
            if (ptr_q == LAST) begin
               if (down_q) state_d = ST_DONE;
               else        state_d = rise_if ? ST_IFHI : ST_PLL;
            end else begin
               ptr_d = ptr_q + 1'b1;
            end
         end
         ST_IFHI: state_d = ST_PLL;
         ST_PLL: begin
            cur_d   = tbl_rate;
            state_d = ST_WAIT;
         end
         ST_WAIT: begin
            if (timer_expire) begin
               ptr_d = '0;
               if (!pll_lock) begin
                  res_d   = RES_TIMEOUT;
                  state_d = ST_DONE;
               end else if (pll_err) begin
                  res_d   = RES_BADSTAT;
                  state_d = ST_DONE;
               end else if (fall_if) begin
                  state_d = ST_IFLO;
               end else begin
                  state_d = down_q ? ST_DIV : ST_DONE;
               end
            end
         end
         ST_IFLO: state_d = down_q ? ST_DIV : ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         res_q   <= RES_OK;
         ptr_q   <= '0;
         idx_q   <= '0;
         cur_q   <= RATE_W'(INIT_RATE);
         down_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         res_q   <= res_d;
         ptr_q   <= ptr_d;
         idx_q   <= idx_d;
         cur_q   <= cur_d;
         down_q  <= down_d;
      end
   end

   logic [7:0] div_byte;
   assign div_byte = tbl_divs[int'(ptr_q)*8 +: 8];

   always_comb begin
      wr_en   = 1'b0;
      wr_addr = '0;
      wr_data = '0;
      case (state_q)
         ST_DIV: begin
            wr_en   = 1'b1;
            wr_addr = A_BASE + ADDR_W'(ptr_q) * A_STEP;
            wr_data = DATA_W'(div_byte);
         end
         ST_IFHI: begin
            wr_en   = 1'b1;
            wr_addr = A_IF;
            wr_data = DATA_W'(1);
         end
         ST_PLL: begin
            wr_en   = 1'b1;
            wr_addr = A_PLL;
            wr_data = DATA_W'(tbl_cfg);
         end
         ST_IFLO: begin
            wr_en   = 1'b1;
            wr_addr = A_IF;
            wr_data = '0;
         end
         default: ;
      endcase
   end

   assign sel        = idx_q;
   assign timer_load = (state_q == ST_PLL);
   assign busy       = (state_q != ST_IDLE);
   assign done       = (state_q == ST_DONE);
   assign result     = res_q;

   // assertion-only record of writes in the current sequence
   logic any_wr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  any_wr_q <= 1'b0;
      else if (state_q == ST_IDLE) any_wr_q <= 1'b0;
      else if (wr_en)              any_wr_q <= 1'b1;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R13
   AST_IDX_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(idx_q)); // R2
   AST_BADIDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && result == RES_BADIDX) |-> !any_wr_q); // R3
   AST_PLL_STARTS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_PLL && state_q == ST_PLL) |=> timer_running); // R7
   AST_TIMEOUT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && timer_expire && !pll_lock) |=> (done && result == RES_TIMEOUT && !wr_en)); // R8
   AST_BADSTAT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && timer_expire && pll_lock && pll_err) |=> (done && result == RES_BADSTAT && !wr_en)); // R9
   AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DIV && ptr_q != LAST) |=> (wr_en && wr_addr == $past(wr_addr) + A_STEP)); // R6
   AST_IFHI_BEFORE_PLL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PLL && rise_if) |-> $past(wr_en && wr_addr == A_IF && wr_data == DATA_W'(1))); // R11

endmodule

// File: rtl/clk_retarget_seq.sv
module clk_retarget_seq #(
   parameter int unsigned NUM_PTS    = 4,
   parameter int unsigned NUM_DIV    = 3,
   parameter int unsigned IDX_W      = 2,
   parameter int unsigned RATE_W     = 16,
   parameter int unsigned CFG_W      = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CLK_MHZ    = 100,
   parameter int unsigned LOCK_US    = 100,
   parameter int unsigned INIT_RATE  = 400,
   parameter int unsigned THRESH_MHZ = 500,
   parameter bit          IS_CORE    = 1'b1,
   parameter int unsigned PLL_ADDR   = 0,
   parameter int unsigned IFDIV_ADDR = 4,
   parameter int unsigned DIV_BASE   = 16,
   parameter int unsigned DIV_STRIDE = 4,
   parameter logic [NUM_PTS*RATE_W-1:0] PT_RATE =
      {16'd800, 16'd600, 16'd400, 16'd200},
   parameter logic [NUM_PTS*CFG_W-1:0]  PT_CFG =
      {32'h0000_2E04, 32'h0000_2204, 32'h0000_5E18, 32'h0000_5E1C},
   parameter logic [NUM_PTS*NUM_DIV*8-1:0] PT_DIV =
      96'h02_01_04_02_01_03_02_02_04_02_04_04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  idx,
   input  logic              pll_lock,
   input  logic              pll_err,
   output logic              busy,
   output logic              done,
   output logic [1:0]        result,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);

   localparam int unsigned LOCK_CYC = CLK_MHZ * LOCK_US;

   if (NUM_PTS < 1 || NUM_DIV < 1) begin : g_bad_size
      $error("clk_retarget_seq: need at least one preset and one divider");
   end
   if ((1 << IDX_W) < NUM_PTS) begin : g_bad_idx
      $error("clk_retarget_seq: IDX_W too narrow for NUM_PTS");
   end
   if (LOCK_CYC < 1) begin : g_bad_lock
      $error("clk_retarget_seq: lock interval must be at least one cycle");
   end
   if (CFG_W > DATA_W || DATA_W < 8) begin : g_bad_data
      $error("clk_retarget_seq: write data too narrow");
   end
   if (DIV_BASE + (NUM_DIV - 1) * DIV_STRIDE >= (1 << ADDR_W)) begin : g_bad_addr
      $error("clk_retarget_seq: divider addresses exceed ADDR_W");
   end

   logic [IDX_W-1:0]     sel;
   logic                 tbl_hit;
   logic [RATE_W-1:0]    tbl_rate;
   logic [CFG_W-1:0]     tbl_cfg;
   logic [NUM_DIV*8-1:0] tbl_divs;
   logic                 timer_load, timer_running, timer_expire;

   clkseq_table #(
      .NUM_PTS (NUM_PTS), .NUM_DIV (NUM_DIV), .IDX_W (IDX_W),
      .RATE_W  (RATE_W),  .CFG_W   (CFG_W),
      .PT_RATE (PT_RATE), .PT_CFG  (PT_CFG), .PT_DIV (PT_DIV)
   ) u_table (
      .sel  (sel),
      .hit  (tbl_hit),
      .rate (tbl_rate),
      .cfg  (tbl_cfg),
      .divs (tbl_divs)
   );

   clkseq_lock_timer #(.LOCK_CYC (LOCK_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (timer_load),
      .running (timer_running),
      .expire  (timer_expire)
   );

   clkseq_fsm #(
      .NUM_DIV    (NUM_DIV),    .IDX_W      (IDX_W),
      .RATE_W     (RATE_W),     .CFG_W      (CFG_W),
      .ADDR_W     (ADDR_W),     .DATA_W     (DATA_W),
      .INIT_RATE  (INIT_RATE),  .THRESH_MHZ (THRESH_MHZ),
      .IS_CORE    (IS_CORE),    .PLL_ADDR   (PLL_ADDR),
      .IFDIV_ADDR (IFDIV_ADDR), .DIV_BASE   (DIV_BASE),
      .DIV_STRIDE (DIV_STRIDE)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .idx           (idx),
      .pll_lock      (pll_lock),
      .pll_err       (pll_err),
      .tbl_hit       (tbl_hit),
      .tbl_rate      (tbl_rate),
      .tbl_cfg       (tbl_cfg),
      .tbl_divs      (tbl_divs),
      .timer_expire  (timer_expire),
      .timer_running (timer_running),
      .sel           (sel),
      .timer_load    (timer_load),
      .busy          (busy),
      .done          (done),
      .result        (result),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data)
   );

   AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R1

endmodule

// File: tb/clk_retarget_seq_bench.sv
module clk_retarget_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 6, ND = 3, IW = 3, RW = 16, CW = 32, AW = 8, DW = 32;
   localparam int CLK_MHZ = 2, LOCK_US = 4, LOCK_CYC = CLK_MHZ * LOCK_US;
   localparam int INIT = 400, THR = 500;
   localparam int A_PLL = 0, A_IF = 4, DBASE = 16, DSTR = 4;

   function automatic int f_rate(int p);
      case (p)
         0: return 300;
         1: return 500;
         2: return 501;
         3: return 800;
         5: return 200;
         default: return 0;
      endcase
   endfunction

   function automatic int f_div(int p, int k);
      if (p == 5 && k == 1) return 0;
      return (p * 16 + k + 1) & 255;
   endfunction

   function automatic int f_cfg(int p);
      return 32'hC000 + p;
   endfunction

   function automatic logic [NP*RW-1:0] f_rates();
      logic [NP*RW-1:0] v;
      v = '0;
      for (int p = 0; p < NP; p++) v[p*RW +: RW] = RW'(f_rate(p));
      return v;
   endfunction

   function automatic logic [NP*CW-1:0] f_cfgs();
      logic [NP*CW-1:0] v;
      v = '0;
      for (int p = 0; p < NP; p++) v[p*CW +: CW] = CW'(f_cfg(p));
      return v;
   endfunction

   function automatic logic [NP*ND*8-1:0] f_divs();
      logic [NP*ND*8-1:0] v;
      v = '0;
      for (int p = 0; p < NP; p++)
         for (int k = 0; k < ND; k++) v[(p*ND+k)*8 +: 8] = 8'(f_div(p, k));
      return v;
   endfunction

   localparam logic [NP*RW-1:0]   P_RATE = f_rates();
   localparam logic [NP*CW-1:0]   P_CFG  = f_cfgs();
   localparam logic [NP*ND*8-1:0] P_DIV  = f_divs();

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [IW-1:0] idx = '0;
   logic          pll_lock = 1'b0;
   logic          pll_err = 1'b0;
   logic          busy, done, wr_en;
   logic [1:0]    result;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_retarget_seq #(
      .NUM_PTS (NP), .NUM_DIV (ND), .IDX_W (IW), .RATE_W (RW), .CFG_W (CW),
      .ADDR_W (AW), .DATA_W (DW), .CLK_MHZ (CLK_MHZ), .LOCK_US (LOCK_US),
      .INIT_RATE (INIT), .THRESH_MHZ (THR), .IS_CORE (1'b1),
      .PLL_ADDR (A_PLL), .IFDIV_ADDR (A_IF), .DIV_BASE (DBASE), .DIV_STRIDE (DSTR),
      .PT_RATE (P_RATE), .PT_CFG (P_CFG), .PT_DIV (P_DIV)
   ) u_clk_retarget_seq (
      .clk (clk), .rst_n (rst_n), .start (start), .idx (idx),
      .pll_lock (pll_lock), .pll_err (pll_err),
      .busy (busy), .done (done), .result (result),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data)
   );

   int n_chk = 0, n_err = 0;
   bit finished = 0;
   int log_a [32];
   int log_d [32];
   int log_n = 0;
   int done_cnt = 0;
   int res_seen = 0;
   int cyc = 100000;
   int lock_delay = LOCK_CYC;
   bit err_drive = 0;
   int cur_model = INIT;

   task automatic chk(input bit ok, input string req, input string what,
                      input int got, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   // one cycle: sample outputs at the falling edge, then drive status
   task automatic tick();
      @(negedge clk);
      if (wr_en) begin
         if (log_n < 32) begin
            log_a[log_n] = int'(wr_addr);
            log_d[log_n] = int'(wr_data);
         end
         log_n++;
      end
      if (done) begin
         done_cnt++;
         res_seen = int'(result);
      end
      if (wr_en && int'(wr_addr) == A_PLL) cyc = 0;
      else if (cyc < 100000) cyc++;
      pll_lock = (cyc >= lock_delay);
      pll_err  = err_drive;
   endtask

   task automatic run(input int ix, input int dly, input bit er, input bit poke,
                      input string tag);
      int ea [32];
      int ed [32];
      int en;
      int eres;
      int wc;
      int bad;
      bit busy_ok;
      bit valid;
      bit down;
      bit fail;
      int r;
      en = 0;
      valid = (ix < NP) && (f_rate(ix) != 0);
      r = valid ? f_rate(ix) : 0;
      if (!valid) begin
         eres = 3;
      end else begin
         down = r < cur_model;
         if (!down) begin
            for (int k = 0; k < ND; k++) begin
               ea[en] = DBASE + k * DSTR; ed[en] = f_div(ix, k); en++;
            end
         end
         if (r > THR) begin ea[en] = A_IF; ed[en] = 1; en++; end
         ea[en] = A_PLL; ed[en] = f_cfg(ix); en++;
         cur_model = r;
         fail = (dly > LOCK_CYC) || er;
         eres = (dly > LOCK_CYC) ? 1 : (er ? 2 : 0);
         if (!fail) begin
            if (r <= THR) begin ea[en] = A_IF; ed[en] = 0; en++; end
            if (down) begin
               for (int k = 0; k < ND; k++) begin
                  ea[en] = DBASE + k * DSTR; ed[en] = f_div(ix, k); en++;
               end
            end
         end
      end

      tick();
      lock_delay = dly;
      err_drive  = er;
      log_n = 0;
      done_cnt = 0;
      idx   = IW'(ix);
      start = 1'b1;
      tick();
      start = 1'b0;
      busy_ok = busy;
      wc = 0;
      while (done_cnt == 0 && wc < 400) begin
         tick();
         wc++;
         if (poke && wc == 2) begin
            start = 1'b1;
            idx   = IW'((ix + 3) % 8);
         end else begin
            start = 1'b0;
         end
         if (done_cnt == 0 && !busy) busy_ok = 1'b0;
      end
      start = 1'b0;
      chk(done_cnt == 1, "R2", {tag, " completion seen"}, done_cnt, 1);
      chk(busy_ok, "R2", {tag, " busy held until done"}, int'(busy_ok), 1);
      chk(res_seen == eres, (eres == 3) ? "R3" : (eres == 1) ? "R8" : (eres == 2) ? "R9" : "R10",
          {tag, " result"}, res_seen, eres);
      bad = -1;
      for (int i = 0; i < en && i < log_n; i++)
         if (bad < 0 && (log_a[i] != ea[i] || log_d[i] != ed[i])) bad = i;
      chk(log_n == en, "R4/R5/R6/R11/R12", {tag, " write count"}, log_n, en);
      if (bad >= 0)
         chk(1'b0, "R4/R5/R6/R7/R11/R12", {tag, " write addr*65536+data"},
             log_a[bad] * 65536 + log_d[bad], ea[bad] * 65536 + ed[bad]);
      else
         chk(1'b1, "R6", {tag, " write order"}, 0, 0);
      // after completion: single pulse, idle, no second sequence (R13, R2)
      for (int i = 0; i < 4; i++) tick();
      chk(done_cnt == 1 && !busy && log_n == en, "R13",
          {tag, " idle after single done pulse"}, done_cnt * 100 + log_n, 100 + en);
   endtask

   initial begin
      int valid_pts [5];
      valid_pts = '{0, 1, 2, 3, 5};
      // R1: reset state
      for (int i = 0; i < 3; i++) tick();
      chk(!busy && !done && !wr_en, "R1", "outputs in reset",
          int'(busy) + int'(done) + int'(wr_en), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) tick();
      chk(!busy && !done && !wr_en, "R1", "outputs after reset",
          int'(busy) + int'(done) + int'(wr_en), 0);

      // every ordered pair of presets, all indices as target (R4, R5, R11, R12)
      foreach (valid_pts[a]) begin
         for (int b = 0; b < 8; b++) begin
            run(valid_pts[a], LOCK_CYC, 1'b0, 1'b0, "sweep-from");
            run(b, LOCK_CYC, 1'b0, 1'b0, "sweep-to");
         end
      end

      // R7 and R8: lock one cycle after the window gives a timeout, PLL only
      run(3, LOCK_CYC, 1'b0, 1'b0, "setup-800");
      run(0, LOCK_CYC + 1, 1'b0, 1'b0, "R8 late lock");
      // R13: the rate is now 300 even though relock failed: equal rate takes the rising order
      run(0, LOCK_CYC, 1'b0, 1'b0, "R13 rate after timeout");
      // R9: error on a rising change stops after the PLL write
      run(3, LOCK_CYC, 1'b1, 1'b0, "R9 status error");
      // R8: lock never arrives
      run(1, 100000, 1'b0, 1'b0, "R8 no lock");
      // R12: falling below threshold after error-free relock
      run(5, LOCK_CYC, 1'b0, 1'b0, "R12 fall with zero divider");
      // R2: start while busy is ignored
      run(2, LOCK_CYC, 1'b0, 1'b1, "R2 start while busy");
      run(0, LOCK_CYC, 1'b0, 1'b1, "R2 start while busy down");
      // R3: hole and out-of-range indices
      run(4, LOCK_CYC, 1'b0, 1'b0, "R3 table hole");
      run(7, LOCK_CYC, 1'b0, 1'b1, "R3 out of range");
      run(6, LOCK_CYC, 1'b0, 1'b0, "R3 first beyond table");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule